// File: doc/BRIEF.md
# Asynchronous Static Memory Timing Sequencer

This block turns single read or write requests from an internal requester into the strobes of an asynchronous external memory, such as SRAM, ROM or NOR-type parts. It runs on the system clock. Each access walks through up to four phases. The first is address setup. The second is an address hold, which is used only in mode D. The third is the data phase. The fourth is a bus turnaround, which follows writes only. Each phase lasts a programmed number of system-clock cycles.

Two timing words are held inside the block: a read set and a write set. Writes take their timing from the write set only when the extended-mode input is high. Otherwise every access uses the read set. The block latches the selected lengths and the access-mode code when it accepts a request. A one-cycle done pulse marks the end of each access. For reads, the captured read data is valid at that pulse.

Top module: `smt_seq`

## Requirements
- R1: While reset is held, mem_ce_n, mem_oe_n and mem_we_n are 1, mem_dout_en, done and acc_mode are 0, and req_ready is 1. Both timing words reset to setup 15, hold 15, data 255, turnaround 15 and mode 00. A read started just after reset therefore takes 270 cycles.
- R2: The address setup phase lasts N cycles, where N is the setup field (0 to 15). N = 0 omits the phase. mem_ce_n is low for setup + hold + data cycles.
- R3: A request is accepted only while req_ready is 1, and req_ready is 1 only in the idle state. done pulses for one cycle in the first idle cycle after the final phase. Requests seen while busy are ignored, and mem_addr keeps the accepted address.
- R4: The data phase lasts N cycles, where N is the data field (1 to 255). A value of 0 written to that field is stored as 1.
- R5: After a write, the turnaround adds N cycles (0 to 15) with mem_ce_n high before done. Reads never have a turnaround.
- R6: With cfg_ext_mode = 0, writes use the read timing word. With cfg_ext_mode = 1, writes use the write timing word. Reads always use the read timing word.
- R7: acc_mode shows the mode of the current access: 00 = A, 01 = B, 10 = C, 11 = D. It takes the mode field of the selected word when cfg_ext_mode = 1, and is 00 (A) otherwise.
- R8: The address hold phase follows setup and lasts N cycles (the hold field). It is used only when the effective mode is D (11).
- R9: On a read, mem_oe_n is low for the whole active access and rises in the cycle after the last data cycle. rd_data holds mem_din as sampled in the last data cycle.
- R10: On a write, mem_we_n is low only during the data phase. mem_dout_en is high from the start of setup to the end of the data phase, and mem_dout carries the accepted write data.
- R11: Lengths and mode are latched at acceptance. A configuration write during an access does not change that access.
- R12: Timing word layout: setup at bits [3:0], hold at [7:4], data at [15:8], turnaround at [19:16] and mode at [29:28]. cfg_sel = 0 writes the read word and cfg_sel = 1 writes the write word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Timing word write strobe |
| cfg_sel | input | 1 | 0 = read word, 1 = write word |
| cfg_wdata | input | 32 | Timing word value |
| cfg_ext_mode | input | 1 | Enables separate write timing and mode field |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Idle, request can be accepted |
| done | output | 1 | One-cycle end-of-access pulse |
| rd_data | output | DW | Captured read data |
| acc_mode | output | 2 | Effective access mode of current access |
| mem_addr | output | AW | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dout | output | DW | Write data to memory |
| mem_dout_en | output | 1 | Write data driver enable |
| mem_din | input | DW | Read data from memory |

## Verification
The bench sweeps setup lengths of 0, 1 and 3, data lengths of 1, 2 and 5, turnaround lengths of 0 and 2, all four mode codes, both extended-mode settings and both directions. The two timing words are given different values in every field. A length in the wrong field, a write that takes the wrong word, or a hold phase used outside mode D therefore changes the measured cycle counts. The memory data input changes every cycle, so capturing read data one cycle early or late gives a different value. The bench also keeps a conflicting request asserted during each access, which shows whether busy requests are really ignored. Separate runs cover the reset defaults, a stored data value of 0, and a configuration write made in the middle of an access.

// File: rtl/smt_pkg.sv
package smt_pkg;

  localparam int CFG_W = 32;
  localparam int CNT_W = 8;

  typedef struct packed {
    logic [1:0] mode;
    logic [3:0] turn;
    logic [7:0] data;
    logic [3:0] hold;
    logic [3:0] setup;
  } smt_timing_t;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_HOLD  = 3'd2,
    PH_DATA  = 3'd3,
    PH_TURN  = 3'd4
  } smt_phase_e;

  localparam logic [1:0] MODE_A = 2'b00;
  localparam logic [1:0] MODE_D = 2'b11;

  localparam smt_timing_t SMT_RESET = '{mode: 2'b00, turn: 4'hF, data: 8'hFF,
                                        hold: 4'hF, setup: 4'hF};

endpackage

// File: rtl/smt_cfg_regs.sv
module smt_cfg_regs
  import smt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  output smt_timing_t      rd_set,
  output smt_timing_t      wr_set
);

  smt_timing_t new_set;
  logic        unused_rsvd;

  // Field positions R12
  always_comb begin
    new_set.setup = cfg_wdata[3:0];
    new_set.hold  = cfg_wdata[7:4];
    new_set.data  = (cfg_wdata[15:8] == 8'd0) ? 8'd1 : cfg_wdata[15:8]; // R4
    new_set.turn  = cfg_wdata[19:16];
    new_set.mode  = cfg_wdata[29:28];
  end

  assign unused_rsvd = ^{cfg_wdata[31:30], cfg_wdata[27:20]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_set <= SMT_RESET;
      wr_set <= SMT_RESET;
    end else if (cfg_we) begin
      if (cfg_sel) wr_set <= new_set;
      else         rd_set <= new_set;
    end
  end

  assert_data_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_set.data != 8'd0) && (wr_set.data != 8'd0));

endmodule

// File: rtl/smt_timing_sel.sv
module smt_timing_sel
  import smt_pkg::*;
(
  input  smt_timing_t rd_set,
  input  smt_timing_t wr_set,
  input  logic        ext_en,
  input  logic        is_write,
  output logic [3:0]  len_setup,
  output logic [3:0]  len_hold,
  output logic [7:0]  len_data,
  output logic [3:0]  len_turn,
  output logic [1:0]  eff_mode
);

  smt_timing_t chosen;

  always_comb begin
    chosen    = (is_write && ext_en) ? wr_set : rd_set;      // R6
    eff_mode  = ext_en ? chosen.mode : MODE_A;               // R7
    len_setup = chosen.setup;
    len_hold  = (eff_mode == MODE_D) ? chosen.hold : 4'd0;   // R8
    len_data  = chosen.data;
    len_turn  = is_write ? chosen.turn : 4'd0;               // R5
  end

endmodule

// File: rtl/smt_phase_fsm.sv
module smt_phase_fsm
  import smt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [3:0] in_setup,
  input  logic [3:0] in_hold,
  input  logic [7:0] in_data,
  input  logic [3:0] in_turn,
  output smt_phase_e phase,
  output smt_phase_e phase_nxt,
  output logic       last_data,
  output logic       done
);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [3:0]       hold_q, turn_q;
  logic [7:0]       data_q;
  logic             done_n;

  always_comb begin
    phase_nxt = phase;
    cnt_n     = cnt_q;
    done_n    = 1'b0;
    unique case (phase)
      PH_IDLE: if (start) begin
        if (in_setup != 4'd0) begin
          phase_nxt = PH_SETUP;
          cnt_n     = {4'd0, in_setup} - 8'd1;
        end else if (in_hold != 4'd0) begin
          phase_nxt = PH_HOLD;
          cnt_n     = {4'd0, in_hold} - 8'd1;
        end else begin
          phase_nxt = PH_DATA;
          cnt_n     = in_data - 8'd1;
        end
      end
      PH_SETUP: if (cnt_q == '0) begin
        if (hold_q != 4'd0) begin
          phase_nxt = PH_HOLD;
          cnt_n     = {4'd0, hold_q} - 8'd1;
        end else begin
          phase_nxt = PH_DATA;
          cnt_n     = data_q - 8'd1;
        end
      end else cnt_n = cnt_q - 8'd1;
      PH_HOLD: if (cnt_q == '0) begin
        phase_nxt = PH_DATA;
        cnt_n     = data_q - 8'd1;
      end else cnt_n = cnt_q - 8'd1;
      PH_DATA: if (cnt_q == '0) begin
        if (turn_q != 4'd0) begin
          phase_nxt = PH_TURN;
          cnt_n     = {4'd0, turn_q} - 8'd1;
        end else begin
          phase_nxt = PH_IDLE;
          done_n    = 1'b1;
        end
      end else cnt_n = cnt_q - 8'd1;
      PH_TURN: if (cnt_q == '0) begin
        phase_nxt = PH_IDLE;
        done_n    = 1'b1;
      end else cnt_n = cnt_q - 8'd1;
      default: phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      cnt_q  <= '0;
      hold_q <= '0;
      data_q <= 8'd1;
      turn_q <= '0;
      done   <= 1'b0;
    end else begin
      phase <= phase_nxt;
      cnt_q <= cnt_n;
      done  <= done_n;
      if (start && phase == PH_IDLE) begin
        hold_q <= in_hold;
        data_q <= in_data;
        turn_q <= in_turn;
      end
    end
  end

  assign last_data = (phase == PH_DATA) && (cnt_q == '0);

  assert_turn_after_data_R5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_TURN) |-> ($past(phase) == PH_DATA || $past(phase) == PH_TURN));

  assert_data_follows_active_R4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DATA && $past(phase) == PH_IDLE) |-> ($past(in_setup) == 4'd0));

endmodule

// File: rtl/smt_seq.sv
module smt_seq
  import smt_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             cfg_ext_mode,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_ready,
  output logic             done,
  output logic [DW-1:0]    rd_data,
  output logic [1:0]       acc_mode,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_ce_n,
  output logic             mem_oe_n,
  output logic             mem_we_n,
  output logic [DW-1:0]    mem_dout,
  output logic             mem_dout_en,
  input  logic [DW-1:0]    mem_din
);

  smt_timing_t rd_set, wr_set;
  logic [3:0]  len_setup, len_hold, len_turn;
  logic [7:0]  len_data;
  logic [1:0]  sel_mode;
  smt_phase_e  phase, phase_nxt;
  logic        last_data, accept, wr_q, wr_n, active_n;

  smt_cfg_regs u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .rd_set(rd_set), .wr_set(wr_set)
  );

  smt_timing_sel u_sel (
    .rd_set(rd_set), .wr_set(wr_set), .ext_en(cfg_ext_mode), .is_write(req_write),
    .len_setup(len_setup), .len_hold(len_hold), .len_data(len_data),
    .len_turn(len_turn), .eff_mode(sel_mode)
  );

  smt_phase_fsm u_fsm (
    .clk(clk), .rst(rst), .start(accept),
    .in_setup(len_setup), .in_hold(len_hold), .in_data(len_data), .in_turn(len_turn),
    .phase(phase), .phase_nxt(phase_nxt), .last_data(last_data), .done(done)
  );

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;   // R3
  assign wr_n      = accept ? req_write : wr_q;
  assign active_n  = (phase_nxt == PH_SETUP) || (phase_nxt == PH_HOLD) ||
                     (phase_nxt == PH_DATA);

  // Registered strobes, decoded from the next phase so they line up with it
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q        <= 1'b0;
      acc_mode    <= MODE_A;
      mem_addr    <= '0;
      mem_dout    <= '0;
      rd_data     <= '0;
      mem_ce_n    <= 1'b1;
      mem_oe_n    <= 1'b1;
      mem_we_n    <= 1'b1;
      mem_dout_en <= 1'b0;
    end else begin
      if (accept) begin
        wr_q     <= req_write;
        acc_mode <= sel_mode;
        mem_addr <= req_addr;
        mem_dout <= req_wdata;
      end
      if (last_data && !wr_q) rd_data <= mem_din;            // R9
      mem_ce_n    <= !active_n;
      mem_oe_n    <= !(active_n && !wr_n);
      mem_we_n    <= !((phase_nxt == PH_DATA) && wr_n);      // R10
      mem_dout_en <= active_n && wr_n;
    end
  end

  assert_we_in_data_R10: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_dout_en));

  assert_oe_we_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));

  assert_busy_after_accept_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && !$past(req_ready)) |-> $stable(mem_addr));

endmodule

// File: tb/smt_seq_bench.sv
module smt_seq_bench;

  localparam int AW = 16;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0, cfg_sel = 1'b0, cfg_ext_mode = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, done, mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en;
  logic [DW-1:0] rd_data, mem_dout, mem_din;
  logic [1:0] acc_mode;
  logic [AW-1:0] mem_addr;
  logic [31:0] cyc = '0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign mem_din = cyc[15:0] ^ 16'h5A00;

  smt_seq #(.AW(AW), .DW(DW)) u_smt_seq (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_ext_mode(cfg_ext_mode), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready), .done(done),
    .rd_data(rd_data), .acc_mode(acc_mode), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dout(mem_dout),
    .mem_dout_en(mem_dout_en), .mem_din(mem_din)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] tword(input int s, input int h, input int d,
                                        input int t, input int m);
    return {2'b00, m[1:0], 8'h00, t[3:0], d[7:0], h[3:0], s[3:0]};
  endfunction

  task automatic cfg_write(input bit sel, input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // One access; es/eh/ed/et are the expected phase lengths (eh, et already
  // reduced by mode and direction), emode the expected mode code.
  task automatic run_access(input bit wr, input logic [AW-1:0] addr,
                            input logic [DW-1:0] wdata, input int es, input int eh,
                            input int ed, input int et, input logic [1:0] emode,
                            input bit mid_cfg);
    int n = 0, ce_lo = 0, oe_lo = 0, we_lo = 0, den = 0, we_first = -1;
    int bad_addr = 0, bad_rdy = 0, bad_dout = 0, act = es + eh + ed;
    logic [DW-1:0] last_din = '0;
    logic [1:0] mode_seen = 2'b00;
    @(negedge clk);
    chk(req_ready == 1'b1, "R3 ready when idle", int'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wdata;
    @(negedge clk);
    // conflicting request kept up while busy (R3)
    req_write = !wr; req_addr = ~addr; req_wdata = ~wdata;
    mode_seen = acc_mode;
    forever begin
      if (done || n > 2000) break;
      if (!mem_ce_n) ce_lo++;
      if (!mem_oe_n) begin oe_lo++; last_din = mem_din; end
      if (!mem_we_n) begin we_lo++; if (we_first < 0) we_first = n; end
      if (mem_dout_en) begin den++; if (mem_dout != wdata) bad_dout++; end
      if (!mem_ce_n && mem_addr != addr) bad_addr++;
      if (req_ready) bad_rdy++;
      if (mid_cfg && n == 0) begin
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = tword(0, 0, 1, 0, 0);
      end
      if (n == 1) cfg_we = 1'b0;
      n++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    cfg_we = 1'b0;
    chk(n == act + et, "R3 R5 R6 R8 R11 R12 cycles to done", n, act + et);
    chk(ce_lo == act, "R2 ce low cycles", ce_lo, act);
    chk(oe_lo == (wr ? 0 : act), "R9 oe low cycles", oe_lo, wr ? 0 : act);
    chk(we_lo == (wr ? ed : 0), "R10 we low cycles", we_lo, wr ? ed : 0);
    chk(we_first == (wr ? es + eh : -1), "R10 we start", we_first, wr ? es + eh : -1);
    chk(den == (wr ? act : 0), "R10 dout_en cycles", den, wr ? act : 0);
    chk(bad_dout == 0, "R10 dout value", bad_dout, 0);
    chk(mode_seen == emode, "R7 acc_mode", int'(mode_seen), int'(emode));
    chk(bad_addr == 0 && bad_rdy == 0, "R3 busy request ignored", bad_addr + bad_rdy, 0);
    if (!wr) chk(rd_data == last_din, "R9 rd_data", int'(rd_data), int'(last_din));
    @(negedge clk);
    chk(done == 1'b0, "R3 done single pulse", int'(done), 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int sv[3] = '{0, 1, 3};
    int dv[3] = '{1, 2, 5};
    int tv[2] = '{0, 2};
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes high in reset",
        int'({mem_ce_n, mem_oe_n, mem_we_n}), 7);
    chk(!mem_dout_en && !done && acc_mode == 2'b00 && req_ready, "R1 idle outputs",
        int'({mem_dout_en, done, acc_mode, req_ready}), 1);
    @(negedge clk); rst = 1'b0;
    // R1 default timing: setup 15, data 255, mode A so no hold
    run_access(1'b0, 16'h1234, 16'h0, 15, 0, 255, 0, 2'b00, 1'b0);
    // R4 zero data stored as one
    cfg_write(1'b0, tword(1, 0, 0, 0, 0));
    run_access(1'b0, 16'h0042, 16'h0, 1, 0, 1, 0, 2'b00, 1'b0);
    run_access(1'b1, 16'h0043, 16'hBEEF, 1, 0, 1, 0, 2'b00, 1'b0);
    // R11 mid-access configuration write does not alter the running access
    cfg_write(1'b0, tword(2, 0, 6, 0, 0));
    run_access(1'b0, 16'h0777, 16'h0, 2, 0, 6, 0, 2'b00, 1'b1);
    run_access(1'b0, 16'h0778, 16'h0, 0, 0, 1, 0, 2'b00, 1'b0);
    // Sweep: R2 R5 R6 R7 R8 R12
    foreach (sv[i]) foreach (dv[j]) foreach (tv[k])
      for (int m = 0; m < 4; m++)
        for (int e = 0; e < 2; e++)
          for (int w = 0; w < 2; w++) begin
            int s = sv[i], d = dv[j], t = tv[k];
            int ss, hh, dd, tt, mm, addr;
            cfg_write(1'b0, tword(s, 1, d, t, m));
            cfg_write(1'b1, tword(s + 1, 2, d + 1, t + 1, m ^ 1));
            cfg_ext_mode = e[0];
            if (w == 1 && e == 1) begin
              ss = s + 1; hh = 2; dd = d + 1; tt = t + 1; mm = m ^ 1;
            end else begin
              ss = s; hh = 1; dd = d; tt = t; mm = m;
            end
            if (e == 0) mm = 0;
            if (mm != 3) hh = 0;
            if (w == 0) tt = 0;
            addr = (i * 97 + j * 31 + k * 7 + m * 3 + e * 5 + w) & 16'hFFFF;
            run_access(w[0], addr[15:0], ~addr[15:0], ss, hh, dd, tt, mm[1:0], 1'b0);
          end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule